// File: doc/BRIEF.md
# Dual Threshold and Rate-of-Change Alarm

This block watches a set of sensor sample streams and raises alarms when a chosen stream crosses a programmed limit. It has two alarm channels, and each works on its own. A channel picks one source: the supply monitor, the rotation rate, the auxiliary converter input or the temperature. It then compares that source against a threshold word. The threshold word holds a signed limit and a direction bit that says whether the alarm fires above the limit or below it.

A channel works in one of two modes. In level mode it compares the sample value itself. In rate-of-change mode it compares the difference between the current sample and the sample taken a programmed number of strobes earlier. For that it keeps a history of its own selected source values.

The two per-channel status bits are combined into one alarm flag. That flag can be driven onto one of two output lines, and the line has its own enable and polarity controls. Every decision is taken once for each input sample strobe.

Top module: `alarm_monitor`

## Requirements
- R1: Source select codes are 001 = supply monitor, 010 = rotation rate, 101 = auxiliary input and 110 = temperature. The codes 000, 011, 100 and 111 disable the channel, and a disabled channel's status bit is 0 after every sample strobe.
- R2: In the threshold word, bit 15 is the direction (1 = alarm when the compared value is strictly greater than the limit, 0 = alarm when it is strictly less). Bit 14 is ignored. Bits 13:0 hold the limit as a signed 14-bit value.
- R3: In level mode the rotation rate is compared as a signed 14-bit value. The 12-bit sources (supply, auxiliary, temperature) are sign-extended from bit 11 before the comparison.
- R4: The shared input useFiltered selects the filtered rotation-rate stream when it is 1 and the unfiltered stream when it is 0. The other sources are unaffected.
- R5: In rate-of-change mode the compared value is the current sample minus the sample taken W strobes earlier, kept as a signed 15-bit value. W is the 8-bit window count, and a count of 0 or 1 both mean W = 1.
- R6: A rate-of-change channel reports no alarm until W samples have been captured since reset or since its latest configuration change. A change to the source, mode, window or filter selection counts as a configuration change.
- R7: A status bit changes only on the clock edge that samples sampleValid high. Between strobes it holds its value.
- R8: alarmStatus bit 0 belongs to channel 1 and bit 1 to channel 2. alarmFlag is 1 when either bit is 1.
- R9: When alarmEn is 0, both alarmLine bits are 0. When alarmEn is 1, the line chosen by alarmLineSel (1 = alarmLine[1], 0 = alarmLine[0]) shows alarmFlag: as is when alarmActiveHigh is 1, and inverted when it is 0. The unchosen line stays 0.
- R10: After reset, alarmStatus, alarmFlag and alarmLine are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new set of samples |
| supplyIn | input | 12 | Supply monitor sample |
| rateRawIn | input | 14 | Unfiltered rotation-rate sample |
| rateFiltIn | input | 14 | Filtered rotation-rate sample |
| auxIn | input | 12 | Auxiliary converter sample |
| tempIn | input | 12 | Temperature sample |
| useFiltered | input | 1 | Selects the filtered rate stream |
| ch1Thresh | input | 16 | Channel 1 threshold word |
| ch1Src | input | 3 | Channel 1 source select |
| ch1RateMode | input | 1 | Channel 1 mode (1 = rate of change) |
| ch1Window | input | 8 | Channel 1 window count |
| ch2Thresh | input | 16 | Channel 2 threshold word |
| ch2Src | input | 3 | Channel 2 source select |
| ch2RateMode | input | 1 | Channel 2 mode (1 = rate of change) |
| ch2Window | input | 8 | Channel 2 window count |
| alarmEn | input | 1 | Enables the alarm output line |
| alarmActiveHigh | input | 1 | Output polarity |
| alarmLineSel | input | 1 | Chooses which output line carries the alarm |
| alarmStatus | output | 2 | Per-channel status bits |
| alarmFlag | output | 1 | OR of the status bits |
| alarmLine | output | 2 | Alarm output lines |

## Verification
The assertions are checked on every cycle. They cover these behaviours: status bits stay frozen between strobes, a disabled source code never sets its bit, a window change in rate mode suppresses the alarm at the next strobe, and the output lines follow the enable, polarity and line choice. The signed comparisons need specific sample values to show, and so do the strict treatment of a value equal to the limit, the exact distance into the history that the difference reaches, and the number of strobes a rate channel waits before it can fire. Only the bench's directed scenarios can show these.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;
  localparam int DATA_W = 14;
  localparam int AUX_W = 12;
  localparam int HIST_DEPTH = 256;
  localparam int PTR_W = $clog2(HIST_DEPTH);
  localparam int DIFF_W = DATA_W + 1;

  localparam logic [2:0] SRC_SUPPLY = 3'b001;
  localparam logic [2:0] SRC_RATE = 3'b010;
  localparam logic [2:0] SRC_AUX = 3'b101;
  localparam logic [2:0] SRC_TEMP = 3'b110;

  typedef struct packed {
    logic [2:0] src;
    logic rateMode;
    logic [PTR_W-1:0] window;
    logic useFilt;
  } chanCfg_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
    logic histReady;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } chanStrobes_t;
endpackage

// File: rtl/alarm_chan_ctrl.sv
module alarm_chan_ctrl
  import alarm_mon_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sampleValid,
  input  chanCfg_t cfg,
  output chanStrobes_t strobes
);
  localparam int FILL_W = PTR_W + 1;
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_DEPTH);

  chanCfg_t cfgQ;
  logic [FILL_W-1:0] fillCnt;
  logic [PTR_W-1:0] wrPtr;
  logic [FILL_W-1:0] effWin;
  logic cfgChanged;

  assign cfgChanged = (cfg != cfgQ);
  // window counts 0 and 1 both mean one sample back
  assign effWin = (cfg.window < PTR_W'(2)) ? FILL_W'(1) : {1'b0, cfg.window};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
      fillCnt <= '0;
      wrPtr <= '0;
    end else begin
      cfgQ <= cfg;
      if (cfgChanged) begin
        fillCnt <= sampleValid ? FILL_W'(1) : '0;
      end else if (sampleValid && fillCnt != FILL_MAX) begin
        fillCnt <= fillCnt + FILL_W'(1);
      end
      if (sampleValid) begin
        wrPtr <= wrPtr + PTR_W'(1);
      end
    end
  end

  always_comb begin
    strobes.capture = sampleValid;
    strobes.evaluate = sampleValid;
    strobes.histReady = !cfgChanged && (fillCnt >= effWin);
    strobes.wrPtr = wrPtr;
    strobes.rdPtr = wrPtr - effWin[PTR_W-1:0];
  end
endmodule

// File: rtl/alarm_chan_dp.sv
module alarm_chan_dp
  import alarm_mon_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  chanStrobes_t strobes,
  input  chanCfg_t cfg,
  input  logic [15:0] thresh,
  input  logic [AUX_W-1:0] supplyIn,
  input  logic [DATA_W-1:0] rateRawIn,
  input  logic [DATA_W-1:0] rateFiltIn,
  input  logic [AUX_W-1:0] auxIn,
  input  logic [AUX_W-1:0] tempIn,
  output logic status
);
  localparam int EXT_W = DATA_W - AUX_W;

  logic [DATA_W-1:0] selVal;
  logic srcOn;
  logic [DATA_W-1:0] history [HIST_DEPTH];
  logic [DATA_W-1:0] oldVal;
  logic signed [DIFF_W-1:0] diffVal;
  logic signed [DIFF_W-1:0] cmpVal;
  logic signed [DIFF_W-1:0] limit;
  logic hit;
  logic ready;

  always_comb begin
    srcOn = 1'b1;
    unique case (cfg.src)
      SRC_SUPPLY: selVal = {{EXT_W{supplyIn[AUX_W-1]}}, supplyIn};
      SRC_RATE:   selVal = cfg.useFilt ? rateFiltIn : rateRawIn;
      SRC_AUX:    selVal = {{EXT_W{auxIn[AUX_W-1]}}, auxIn};
      SRC_TEMP:   selVal = {{EXT_W{tempIn[AUX_W-1]}}, tempIn};
      default: begin
        selVal = '0;
        srcOn = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      history[strobes.wrPtr] <= selVal;
    end
  end

  assign oldVal = history[strobes.rdPtr];
  assign diffVal = $signed({selVal[DATA_W-1], selVal}) - $signed({oldVal[DATA_W-1], oldVal});
  assign cmpVal = cfg.rateMode ? diffVal : $signed({selVal[DATA_W-1], selVal});
  assign limit = $signed({thresh[DATA_W-1], thresh[DATA_W-1:0]});
  assign hit = thresh[15] ? (cmpVal > limit) : (cmpVal < limit);
  assign ready = !cfg.rateMode || strobes.histReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= 1'b0;
    end else if (strobes.evaluate) begin
      status <= srcOn && ready && hit;
    end
  end
endmodule

// File: rtl/alarm_monitor.sv
module alarm_monitor
  import alarm_mon_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sampleValid,
  input  logic [11:0] supplyIn,
  input  logic [13:0] rateRawIn,
  input  logic [13:0] rateFiltIn,
  input  logic [11:0] auxIn,
  input  logic [11:0] tempIn,
  input  logic useFiltered,
  input  logic [15:0] ch1Thresh,
  input  logic [2:0] ch1Src,
  input  logic ch1RateMode,
  input  logic [7:0] ch1Window,
  input  logic [15:0] ch2Thresh,
  input  logic [2:0] ch2Src,
  input  logic ch2RateMode,
  input  logic [7:0] ch2Window,
  input  logic alarmEn,
  input  logic alarmActiveHigh,
  input  logic alarmLineSel,
  output logic [1:0] alarmStatus,
  output logic alarmFlag,
  output logic [1:0] alarmLine
);
  localparam int N_CH = 2;

  chanCfg_t chCfg [N_CH];
  logic [15:0] chThresh [N_CH];
  logic activeLevel;

  assign chCfg[0] = '{src: ch1Src, rateMode: ch1RateMode, window: ch1Window, useFilt: useFiltered};
  assign chCfg[1] = '{src: ch2Src, rateMode: ch2RateMode, window: ch2Window, useFilt: useFiltered};
  assign chThresh[0] = ch1Thresh;
  assign chThresh[1] = ch2Thresh;

  for (genvar ch = 0; ch < N_CH; ch++) begin : gChan
    chanStrobes_t strobes;

    alarm_chan_ctrl uCtrl (
      .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
      .cfg(chCfg[ch]), .strobes(strobes)
    );

    alarm_chan_dp uDp (
      .clk(clk), .rstN(rstN), .strobes(strobes), .cfg(chCfg[ch]),
      .thresh(chThresh[ch]), .supplyIn(supplyIn), .rateRawIn(rateRawIn),
      .rateFiltIn(rateFiltIn), .auxIn(auxIn), .tempIn(tempIn),
      .status(alarmStatus[ch])
    );
  end

  assign alarmFlag = |alarmStatus;
  assign activeLevel = alarmActiveHigh ? alarmFlag : !alarmFlag;
  assign alarmLine[0] = alarmEn && !alarmLineSel && activeLevel;
  assign alarmLine[1] = alarmEn && alarmLineSel && activeLevel;
endmodule

// File: rtl/alarm_monitor_checker.sv
module alarm_monitor_checker (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic [2:0] ch1Src,
  input logic ch1RateMode,
  input logic [7:0] ch1Window,
  input logic alarmEn,
  input logic alarmActiveHigh,
  input logic alarmLineSel,
  input logic [1:0] alarmStatus,
  input logic alarmFlag,
  input logic [1:0] alarmLine
);
  logic ch1Off;
  assign ch1Off = (ch1Src == 3'b000) || (ch1Src == 3'b011) ||
                  (ch1Src == 3'b100) || (ch1Src == 3'b111);

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(alarmStatus));

  assert_off_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ch1Off) |=> !alarmStatus[0]);

  assert_window_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ch1RateMode && !$stable(ch1Window)) |=> !alarmStatus[0]);

  assert_line_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !alarmEn |-> (alarmLine == 2'b00));

  assert_line_polarity_R9: assert property (@(posedge clk) disable iff (!rstN)
    (alarmEn && alarmActiveHigh) |-> (alarmLine[alarmLineSel] == alarmFlag));

  assert_flag_or_R8: assert property (@(posedge clk) disable iff (!rstN)
    (alarmStatus != 2'b00) |-> alarmFlag);
endmodule

bind alarm_monitor alarm_monitor_checker uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .ch1Src(ch1Src), .ch1RateMode(ch1RateMode), .ch1Window(ch1Window),
  .alarmEn(alarmEn), .alarmActiveHigh(alarmActiveHigh), .alarmLineSel(alarmLineSel),
  .alarmStatus(alarmStatus), .alarmFlag(alarmFlag), .alarmLine(alarmLine)
);

// File: tb/tb_alarm_monitor.sv
module tb_alarm_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [11:0] supplyIn = '0;
  logic [13:0] rateRawIn = '0;
  logic [13:0] rateFiltIn = '0;
  logic [11:0] auxIn = '0;
  logic [11:0] tempIn = '0;
  logic useFiltered = 1'b0;
  logic [15:0] ch1Thresh = '0;
  logic [2:0] ch1Src = '0;
  logic ch1RateMode = 1'b0;
  logic [7:0] ch1Window = '0;
  logic [15:0] ch2Thresh = '0;
  logic [2:0] ch2Src = '0;
  logic ch2RateMode = 1'b0;
  logic [7:0] ch2Window = '0;
  logic alarmEn = 1'b0;
  logic alarmActiveHigh = 1'b0;
  logic alarmLineSel = 1'b0;
  logic [1:0] alarmStatus;
  logic alarmFlag;
  logic [1:0] alarmLine;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_monitor dut (.*);

  function automatic logic [15:0] thr(input bit greater, input int lim);
    return {greater, 1'b0, 14'(lim)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) sampleValid = 1'b1;
    @(negedge clk) sampleValid = 1'b0;
  endtask

  task automatic rateSample(input int v, input int expBit, input string tag);
    @(negedge clk) rateRawIn = 14'(v);
    strobe();
    check(alarmStatus[0] == expBit[0], tag, alarmStatus[0], expBit);
  endtask

  task automatic clearCfg();
    @(negedge clk);
    ch1Src = 3'b000; ch2Src = 3'b000; ch1RateMode = 0; ch2RateMode = 0;
    ch1Window = 0; ch2Window = 0; useFiltered = 0;
    strobe();
  endtask

  task automatic testReset();
    check(alarmStatus == 2'b00, "R10 status", alarmStatus, 0);
    check(alarmFlag == 1'b0, "R10 flag", alarmFlag, 0);
    check(alarmLine == 2'b00, "R10 line", alarmLine, 0);
  endtask

  task automatic testStatic();
    @(negedge clk);
    ch1Src = 3'b010; ch1Thresh = thr(1, 100); rateRawIn = 14'd101;
    strobe();
    check(alarmStatus[0] == 1, "R2 above limit", alarmStatus[0], 1);
    @(negedge clk) rateRawIn = 14'd100;
    strobe();
    check(alarmStatus[0] == 0, "R2 equal not greater", alarmStatus[0], 0);
    @(negedge clk) begin
      ch1Thresh = thr(0, 0); ch1Thresh[14] = 1'b1; rateRawIn = 14'(-5);
    end
    strobe();
    check(alarmStatus[0] == 1, "R3 signed rate below zero (R2 bit14 ignored)", alarmStatus[0], 1);
    @(negedge clk) begin
      ch2Src = 3'b110; ch2Thresh = thr(0, 0); tempIn = 12'hFFF; rateRawIn = 14'd5;
    end
    strobe();
    check(alarmStatus == 2'b10, "R3 temp sign extend / R8 bit order", alarmStatus, 2);
    check(alarmFlag == 1, "R8 flag", alarmFlag, 1);
    @(negedge clk) begin
      ch2Src = 3'b101; ch2Thresh = thr(1, 0); auxIn = 12'h800;
    end
    strobe();
    check(alarmStatus[1] == 0, "R3 aux sign extend", alarmStatus[1], 0);
    @(negedge clk) begin
      ch2Src = 3'b001; ch2Thresh = thr(1, 2000); supplyIn = 12'd2001;
    end
    strobe();
    check(alarmStatus[1] == 1, "R1 supply source", alarmStatus[1], 1);
    clearCfg();
  endtask

  task automatic testDisabled();
    logic [2:0] codes [4] = '{3'b000, 3'b011, 3'b100, 3'b111};
    @(negedge clk) begin
      ch1Thresh = thr(0, 100); supplyIn = 0; rateRawIn = 0; auxIn = 0; tempIn = 0;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) ch1Src = codes[i];
      strobe();
      check(alarmStatus[0] == 0, "R1 disabled code", alarmStatus[0], 0);
    end
    clearCfg();
  endtask

  task automatic testFiltered();
    @(negedge clk) begin
      ch1Src = 3'b010; ch1Thresh = thr(1, 200); rateRawIn = 0; rateFiltIn = 14'd500;
      useFiltered = 1;
    end
    strobe();
    check(alarmStatus[0] == 1, "R4 filtered stream", alarmStatus[0], 1);
    @(negedge clk) useFiltered = 0;
    strobe();
    check(alarmStatus[0] == 0, "R4 raw stream", alarmStatus[0], 0);
    clearCfg();
  endtask

  task automatic testRateWindow();
    @(negedge clk) begin
      ch1Src = 3'b010; ch1RateMode = 1; ch1Window = 8'd3; ch1Thresh = thr(1, 50);
    end
    rateSample(0, 0, "R6 fill 1");
    rateSample(100, 0, "R6 fill 2");
    rateSample(200, 0, "R6 fill 3");
    rateSample(300, 1, "R5 diff vs 3 back");
    rateSample(300, 1, "R5 diff 200");
    rateSample(300, 1, "R5 diff 100");
    rateSample(300, 0, "R5 diff 0");
    @(negedge clk) ch1Window = 8'd1;
    rateSample(1000, 0, "R6 change clears");
    rateSample(1000, 0, "R5 window 1 diff 0");
    rateSample(1100, 1, "R5 window 1 diff 100");
    clearCfg();
  endtask

  task automatic testRateZero();
    @(negedge clk) begin
      ch1Src = 3'b010; ch1RateMode = 1; ch1Window = 8'd0; ch1Thresh = thr(0, -50);
    end
    rateSample(100, 0, "R6 window 0 fill");
    rateSample(0, 1, "R5 window 0 negative diff");
    rateSample(0, 0, "R5 window 0 no change");
    clearCfg();
  endtask

  task automatic testHoldAndLines();
    @(negedge clk) begin
      ch1Src = 3'b010; ch1Thresh = thr(1, 10); rateRawIn = 14'd20;
    end
    strobe();
    @(negedge clk) rateRawIn = 14'd0;
    @(negedge clk);
    @(negedge clk);
    check(alarmStatus[0] == 1, "R7 hold between strobes", alarmStatus[0], 1);
    @(negedge clk) begin alarmEn = 0; alarmActiveHigh = 1; end
    @(negedge clk) check(alarmLine == 2'b00, "R9 disabled", alarmLine, 0);
    @(negedge clk) begin alarmEn = 1; alarmLineSel = 0; end
    @(negedge clk) check(alarmLine == 2'b01, "R9 line0 high", alarmLine, 1);
    @(negedge clk) alarmLineSel = 1;
    @(negedge clk) check(alarmLine == 2'b10, "R9 line1 high", alarmLine, 2);
    @(negedge clk) alarmActiveHigh = 0;
    @(negedge clk) check(alarmLine == 2'b00, "R9 active low asserted", alarmLine, 0);
    strobe();
    check(alarmStatus[0] == 0, "R7 update at strobe", alarmStatus[0], 0);
    check(alarmLine == 2'b10, "R9 active low idle", alarmLine, 2);
    @(negedge clk) alarmLineSel = 0;
    @(negedge clk) check(alarmLine == 2'b01, "R9 active low idle line0", alarmLine, 1);
    @(negedge clk) alarmEn = 0;
    clearCfg();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStatic();
    testDisabled();
    testFiltered();
    testRateWindow();
    testRateZero();
    testHoldAndLines();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule